// File: doc/BRIEF.md
# One-Time-Programmable Array Write-and-Verify Sequencer

This block burns a byte image into a one-time-programmable array over a plain asynchronous memory port. The port has an address, write data, read data, an active-low chip enable, an active-low output enable and an active-low program strobe. A single `start` pulse launches a run over an inclusive address window. For each address the sequencer fires fixed-width program pulses and reads the cell back after each one. It keeps pulsing until the byte matches or the retry budget runs out. Once the window is written, a separate pass reads every byte back and compares it, and the run then ends with a pass/fail verdict, an error class and the first failing address.

In this array an erased cell reads all ones, and a pulse can only clear bits. Bit 0 of address zero acts as a read-protection fuse: once it is cleared, every read returns all ones. The sequencer therefore writes address zero with that bit held at one during the main pass. If the image asks for the fuse, the sequencer blows it as the final step, after the full readback has passed. Two status outputs mark the high-voltage programming phase and the nominal-supply verify phase, so an external supply switch can follow them.

Top module: `otp_prog_seq`

## Requirements
- R1: A program pulse holds `mem_pgm_n` low for exactly `PULSE_CYC` consecutive cycles. During the pulse `mem_ce_n` is low, `mem_oe_n` is high, and `mem_addr` and `mem_wdata` stay constant.
- R2: Each pulse is followed by exactly one read cycle, with `mem_ce_n` and `mem_oe_n` low and `mem_pgm_n` high. On a mismatch another pulse starts on the next cycle at the same address. On a match, programming moves on to the next address.
- R3: If a byte still mismatches after `MAX_TRY` pulses (default 25), the run ends with `done`=1, `pass`=0, `err_code`=2'b01 and `fail_addr` set to that address. No further strobe is issued.
- R4: Addresses are visited in ascending order from `start_addr` to `end_addr` inclusive. A one-address window is allowed, including the top address 17'h1FFFF.
- R5: After the last address has been programmed, one read cycle is made per address in ascending order, with `vfy_phase`=1, `hv_phase`=0 and no program pulse.
- R6: The first mismatch in the final readback ends the run with `done`=1, `pass`=0, `err_code`=2'b10 and `fail_addr` set to that address.
- R7: During the main pass and the readback, address 0 is written and compared with bit 0 forced to 1. If image byte 0 has bit 0 = 0, the readback is followed by a pulse-and-read loop at address 0 that drives the unmasked image byte. That loop expects 8'hFF on read-back, because the fuse is bit 0 of address 0 and a cleared fuse makes every read return all ones. It uses the same retry limit and the same error code as R3.
- R8: A run with no error ends with `done`=1, `pass`=1 and `err_code`=2'b00. While `done` is high, all three strobes are high.
- R9: `hv_phase` is high exactly in pulse cycles and programming read cycles. `vfy_phase` is high exactly in final-readback cycles. Both are low when the block is idle or done.
- R10: After reset all strobes are high and `done`, `pass`, `err_code`, `hv_phase` and `vfy_phase` are 0. `start` is accepted when the block is idle or done, and it clears the previous verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a run (idle or done only) |
| start_addr | input | AW | First address of the window |
| end_addr | input | AW | Last address of the window (not below start) |
| img_addr | output | AW | Address of the image byte wanted |
| img_data | input | DW | Image byte at `img_addr`, combinational |
| mem_addr | output | AW | Array address |
| mem_wdata | output | DW | Array write data |
| mem_rdata | input | DW | Array read data |
| mem_ce_n | output | 1 | Array chip enable, active low |
| mem_oe_n | output | 1 | Array output enable, active low |
| mem_pgm_n | output | 1 | Array program strobe, active low |
| hv_phase | output | 1 | Programming-voltage phase |
| vfy_phase | output | 1 | Final readback phase |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished without error |
| err_code | output | 2 | 00 none, 01 retry overflow, 10 readback mismatch |
| fail_addr | output | AW | Address of the failure |

## Verification
The bench goes after cells that need several pulses, including exactly the 25th. A design with an off-by-one limit would abort good silicon at that cell, while one that allowed a 26th pulse would never report the cell that needs 26. A neighbour-disturb fault clears an already-verified byte when a later address is pulsed; only a real second readback reports that byte as the failing address. The fuse case checks that bit 0 of address 0 is held back until after the readback. A sequencer that burned it early would see all-ones everywhere and fail its own verify. A one-byte window at the top address catches loop-termination and width errors.

// File: rtl/otp_seq_pkg.sv
// Shared types for the OTP write-and-verify sequencer.
package otp_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_PREAD,
        ST_VREAD,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'b00,
        ERR_RETRY  = 2'b01,
        ERR_VERIFY = 2'b10
    } seq_err_t;
endpackage

// File: rtl/otp_pulse_timer.sv
// Counts the cycles of one program pulse.
// Assumes run stays high for a whole pulse and drops for at least one cycle between pulses.
module otp_pulse_timer #(
    parameter int PULSE_CYC = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CW = $clog2(PULSE_CYC + 1);
    localparam logic [CW-1:0] LAST_V = CW'(PULSE_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Cycle count inside the current pulse, cleared between pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    assign last = run && (cnt_q == LAST_V);
endmodule

// File: rtl/otp_try_counter.sv
// Counts program pulses applied to the current byte.
// clear loads 1 (the pulse about to start); inc adds one pulse.
module otp_try_counter #(
    parameter int MAX_TRY = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic at_limit
);
    localparam int TW = $clog2(MAX_TRY + 1);
    localparam logic [TW-1:0] LIMIT_V = TW'(MAX_TRY);

    logic [TW-1:0] cnt_q;

    // Pulse count for the byte in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clear) cnt_q <= TW'(1);
        else if (inc)   cnt_q <= cnt_q + 1'b1;
    end

    assign at_limit = (cnt_q == LIMIT_V);
endmodule

// File: rtl/otp_addr_walker.sv
// Holds the address window and the current address.
// Assumes the last address is not below the first one.
module otp_addr_walker #(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] first,
    input  logic [AW-1:0] final_addr,
    input  logic          rewind,
    input  logic          to_zero,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          at_last
);
    logic [AW-1:0] base_q, end_q, addr_q;

    // Window bounds, captured at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            end_q  <= '0;
        end else if (load) begin
            base_q <= first;
            end_q  <= final_addr;
        end
    end

    // Current address: load, rewind to base, jump to zero or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (load)    addr_q <= first;
        else if (rewind)  addr_q <= base_q;
        else if (to_zero) addr_q <= '0;
        else if (step)    addr_q <= addr_q + 1'b1;
    end

    assign addr    = addr_q;
    assign at_last = (addr_q == end_q);
endmodule

// File: rtl/otp_prog_seq.sv
// Top of the OTP write-and-verify sequencer.
// Programs each byte of a window with timed pulses and read-back retries,
// then reads the whole window again, then optionally blows the read fuse
// (bit 0 of address 0). Assumes img_data is a combinational function of img_addr
// and the array's mem_rdata is valid in the same cycle as the read strobes.
module otp_prog_seq #(
    parameter int AW        = 17,
    parameter int DW        = 8,
    parameter int PULSE_CYC = 12500,
    parameter int MAX_TRY   = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] end_addr,
    output logic [AW-1:0] img_addr,
    input  logic [DW-1:0] img_data,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_pgm_n,
    output logic          hv_phase,
    output logic          vfy_phase,
    output logic          done,
    output logic          pass,
    output logic [1:0]    err_code,
    output logic [AW-1:0] fail_addr
);
    import otp_seq_pkg::*;

    localparam logic [DW-1:0] FUSE_BIT = {{(DW-1){1'b0}}, 1'b1};

    seq_state_t    state_q, state_d;
    logic          in_sec_q, sec_req_q, done_q, pass_q;
    seq_err_t      err_q;
    logic [AW-1:0] fail_q;

    logic          w_load, w_rewind, w_zero, w_step;
    logic [AW-1:0] addr;
    logic          at_last;
    logic          t_last;
    logic          tr_clear, tr_inc, tr_limit;
    logic          launch, go_sec, fin_pass, fin_retry, fin_vfy;

    logic          at_zero;
    logic [DW-1:0] img_fix, wr_data, exp_read;
    logic          rd_match, vf_match;

    otp_addr_walker #(.AW(AW)) u_walk (
        .clk(clk), .rst_n(rst_n), .load(w_load), .first(start_addr),
        .final_addr(end_addr), .rewind(w_rewind), .to_zero(w_zero),
        .step(w_step), .addr(addr), .at_last(at_last)
    );

    otp_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_PULSE), .last(t_last)
    );

    otp_try_counter #(.MAX_TRY(MAX_TRY)) u_tries (
        .clk(clk), .rst_n(rst_n), .clear(tr_clear), .inc(tr_inc),
        .at_limit(tr_limit)
    );

    // Data to write and value expected back, with the fuse bit held off in the main pass.
    always_comb begin
        at_zero  = (addr == '0);
        img_fix  = at_zero ? (img_data | FUSE_BIT) : img_data;
        wr_data  = in_sec_q ? img_data : img_fix;
        exp_read = in_sec_q ? '1 : img_fix;
        rd_match = (mem_rdata == exp_read);
        vf_match = (mem_rdata == img_fix);
    end

    // Next-state and control-strobe decode.
    always_comb begin
        state_d   = state_q;
        w_load    = 1'b0;
        w_rewind  = 1'b0;
        w_zero    = 1'b0;
        w_step    = 1'b0;
        tr_clear  = 1'b0;
        tr_inc    = 1'b0;
        launch    = 1'b0;
        go_sec    = 1'b0;
        fin_pass  = 1'b0;
        fin_retry = 1'b0;
        fin_vfy   = 1'b0;
        case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    launch   = 1'b1;
                    w_load   = 1'b1;
                    tr_clear = 1'b1;
                    state_d  = ST_PULSE;
                end
            end
            ST_PULSE: begin
                if (t_last) state_d = ST_PREAD;
            end
            ST_PREAD: begin
                if (rd_match) begin
                    if (in_sec_q) begin
                        fin_pass = 1'b1;
                        state_d  = ST_DONE;
                    end else if (at_last) begin
                        w_rewind = 1'b1;
                        state_d  = ST_VREAD;
                    end else begin
                        w_step   = 1'b1;
                        tr_clear = 1'b1;
                        state_d  = ST_PULSE;
                    end
                end else if (tr_limit) begin
                    fin_retry = 1'b1;
                    state_d   = ST_DONE;
                end else begin
                    tr_inc  = 1'b1;
                    state_d = ST_PULSE;
                end
            end
            ST_VREAD: begin
                if (!vf_match) begin
                    fin_vfy = 1'b1;
                    state_d = ST_DONE;
                end else if (at_last) begin
                    if (sec_req_q) begin
                        go_sec   = 1'b1;
                        w_zero   = 1'b1;
                        tr_clear = 1'b1;
                        state_d  = ST_PULSE;
                    end else begin
                        fin_pass = 1'b1;
                        state_d  = ST_DONE;
                    end
                end else begin
                    w_step = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Fuse bookkeeping: whether the fuse is wanted, and whether it is being blown.
    always_ff @(posedge clk) begin
        if (!rst_n || launch) begin
            in_sec_q  <= 1'b0;
            sec_req_q <= 1'b0;
        end else begin
            if (go_sec) in_sec_q <= 1'b1;
            if (state_q == ST_PULSE && !in_sec_q && at_zero && !img_data[0])
                sec_req_q <= 1'b1;
        end
    end

    // Verdict registers.
    always_ff @(posedge clk) begin
        if (!rst_n || launch) begin
            done_q <= 1'b0;
            pass_q <= 1'b0;
            err_q  <= ERR_NONE;
            fail_q <= '0;
        end else if (fin_pass) begin
            done_q <= 1'b1;
            pass_q <= 1'b1;
        end else if (fin_retry || fin_vfy) begin
            done_q <= 1'b1;
            err_q  <= fin_retry ? ERR_RETRY : ERR_VERIFY;
            fail_q <= addr;
        end
    end

    assign img_addr  = addr;
    assign mem_addr  = addr;
    assign mem_wdata = wr_data;
    assign mem_pgm_n = (state_q != ST_PULSE);
    assign mem_ce_n  = !(state_q == ST_PULSE || state_q == ST_PREAD || state_q == ST_VREAD);
    assign mem_oe_n  = !(state_q == ST_PREAD || state_q == ST_VREAD);
    assign hv_phase  = (state_q == ST_PULSE || state_q == ST_PREAD);
    assign vfy_phase = (state_q == ST_VREAD);
    assign done      = done_q;
    assign pass      = pass_q;
    assign err_code  = err_q;
    assign fail_addr = fail_q;
endmodule

// File: rtl/otp_seq_checks.sv
// Protocol checker for otp_prog_seq, bound to every instance.
// Counts pulse widths and pulses per address itself, so no deep $past is needed.
module otp_seq_checks #(
    parameter int AW        = 17,
    parameter int DW        = 8,
    parameter int PULSE_CYC = 12500,
    parameter int MAX_TRY   = 25
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_pgm_n,
    input logic          hv_phase,
    input logic          vfy_phase,
    input logic          done,
    input logic          pass,
    input logic [1:0]    err_code
);
    logic [31:0]   plen_q;
    logic [31:0]   pcnt_q;
    logic [AW-1:0] paddr_q;
    logic          prev_pgm_q;

    // Length of the current or just-ended low strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          plen_q <= '0;
        else if (!mem_pgm_n) plen_q <= plen_q + 1;
        else                 plen_q <= '0;
    end

    // Pulses issued at one address since the last address change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q     <= '0;
            paddr_q    <= '0;
            prev_pgm_q <= 1'b1;
        end else begin
            prev_pgm_q <= mem_pgm_n;
            if (vfy_phase || done) begin
                pcnt_q <= '0;
            end else if (prev_pgm_q && !mem_pgm_n) begin
                pcnt_q  <= (mem_addr == paddr_q && pcnt_q != 0) ? pcnt_q + 1 : 1;
                paddr_q <= mem_addr;
            end
        end
    end

    assert_strobe_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_pgm_n |-> (!mem_ce_n && mem_oe_n));
    assert_pulse_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_pgm_n && $past(!mem_pgm_n)) |-> ($stable(mem_addr) && $stable(mem_wdata)));
    assert_pulse_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_pgm_n) |-> (plen_q == PULSE_CYC));
    assert_read_after_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_pgm_n) |-> (!mem_oe_n && !mem_ce_n));
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_q <= MAX_TRY);
    assert_verify_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vfy_phase |-> (mem_pgm_n && !mem_oe_n));
    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_pgm_n && mem_ce_n && mem_oe_n));
    assert_pass_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> (err_code == 2'b00));
    assert_phase_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hv_phase, vfy_phase, done}));
endmodule

bind otp_prog_seq otp_seq_checks #(
    .AW(AW), .DW(DW), .PULSE_CYC(PULSE_CYC), .MAX_TRY(MAX_TRY)
) u_checks (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_pgm_n(mem_pgm_n),
    .hv_phase(hv_phase), .vfy_phase(vfy_phase), .done(done), .pass(pass),
    .err_code(err_code)
);

// File: tb/otp_prog_seq_test.sv
// Bench: a behavioural OTP array plus a trace model that predicts every cycle.
module otp_prog_seq_test;
    localparam int AW = 17, DW = 8, PCYC = 8, MAXT = 25;

    typedef struct packed {
        logic ce_n, oe_n, pgm_n, hv, vfy, dn;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } ent_t;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [AW-1:0] start_addr = '0, end_addr = '0;
    logic [AW-1:0] img_addr, mem_addr, fail_addr;
    logic [DW-1:0] img_data, mem_wdata, mem_rdata;
    logic mem_ce_n, mem_oe_n, mem_pgm_n, hv_phase, vfy_phase, done, pass;
    logic [1:0] err_code;

    int vectors = 0, fails = 0;
    int seed = 1;
    bit use_b0 = 0;
    logic [7:0] byte0 = 8'hFF;
    logic [7:0] mem_a[int], sh_a[int];
    int hit_a[int], hit_s[int], need_m[int];
    int dsrc = -1, dvic = 0;
    logic [7:0] dmask = 8'h00;
    ent_t q[$];
    int exp_err, exp_fail;

    otp_prog_seq #(.AW(AW), .DW(DW), .PULSE_CYC(PCYC), .MAX_TRY(MAXT)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .end_addr(end_addr), .img_addr(img_addr), .img_data(img_data),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_pgm_n(mem_pgm_n),
        .hv_phase(hv_phase), .vfy_phase(vfy_phase), .done(done), .pass(pass),
        .err_code(err_code), .fail_addr(fail_addr)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] img_fn(int a);
        if (a == 0 && use_b0) return byte0;
        return 8'(a * 37 + seed * 11 + 5) | 8'h10;
    endfunction

    always @(img_addr, seed, use_b0, byte0) img_data = img_fn(int'(img_addr));

    function automatic logic [7:0] raw(bit sh, int a);
        if (sh) return sh_a.exists(a) ? sh_a[a] : 8'hFF;
        return mem_a.exists(a) ? mem_a[a] : 8'hFF;
    endfunction

    // Read through the fuse: bit 0 of address 0 cleared hides everything.
    function automatic logic [7:0] rd(bit sh, int a);
        if (raw(sh, 0)[0] == 1'b0) return 8'hFF;
        return raw(sh, a);
    endfunction

    function automatic void pulse(bit sh, int a, logic [7:0] d);
        int n = need_m.exists(a) ? need_m[a] : 1;
        int h;
        if (sh) begin
            h = (hit_s.exists(a) ? hit_s[a] : 0) + 1;
            hit_s[a] = h;
            if (h >= n) sh_a[a] = raw(1, a) & d;
            if (a == dsrc) sh_a[dvic] = raw(1, dvic) & dmask;
        end else begin
            h = (hit_a.exists(a) ? hit_a[a] : 0) + 1;
            hit_a[a] = h;
            if (h >= n) mem_a[a] = raw(0, a) & d;
            if (a == dsrc) mem_a[dvic] = raw(0, dvic) & dmask;
        end
    endfunction

    // Array model: counts strobe width, commits full-width pulses, drives read data.
    int plen = 0, pa = 0;
    logic [7:0] pd = 8'hFF;
    always @(negedge clk) begin
        if (!mem_ce_n && !mem_pgm_n) begin
            plen = plen + 1;
            pa = int'(mem_addr);
            pd = mem_wdata;
        end else begin
            if (plen == PCYC) pulse(0, pa, pd);
            plen = 0;
        end
        mem_rdata = (!mem_ce_n && !mem_oe_n) ? rd(0, int'(mem_addr)) : 8'hFF;
    end

    function automatic ent_t mk(logic ce, logic oe, logic pg, logic hv, logic vf,
                                logic dn, int a, logic [7:0] d);
        ent_t e;
        e.ce_n = ce; e.oe_n = oe; e.pgm_n = pg; e.hv = hv; e.vfy = vf; e.dn = dn;
        e.a = AW'(a); e.d = d;
        return e;
    endfunction

    function automatic bit prog(int a, logic [7:0] w, logic [7:0] x);
        for (int t = 1; t <= MAXT; t++) begin
            for (int c = 0; c < PCYC; c++) q.push_back(mk(0, 1, 0, 1, 0, 0, a, w));
            pulse(1, a, w);
            q.push_back(mk(0, 0, 1, 1, 0, 0, a, w));
            if (rd(1, a) == x) return 1;
        end
        return 0;
    endfunction

    // Predict the whole run on a shadow array.
    function automatic void build(int s, int e);
        bit sec = 0;
        logic [7:0] w;
        q.delete(); sh_a.delete(); hit_s.delete();
        exp_err = 0; exp_fail = 0;
        for (int a = s; a <= e; a++) begin
            w = (a == 0) ? (img_fn(0) | 8'h01) : img_fn(a);
            if (a == 0 && img_fn(0)[0] == 1'b0) sec = 1;
            if (!prog(a, w, w)) begin
                q.push_back(mk(1, 1, 1, 0, 0, 1, 0, 0));
                exp_err = 1; exp_fail = a;
                return;
            end
        end
        for (int a = s; a <= e; a++) begin
            w = (a == 0) ? (img_fn(0) | 8'h01) : img_fn(a);
            q.push_back(mk(0, 0, 1, 0, 1, 0, a, w));
            if (rd(1, a) != w) begin
                q.push_back(mk(1, 1, 1, 0, 0, 1, 0, 0));
                exp_err = 2; exp_fail = a;
                return;
            end
        end
        if (sec && !prog(0, img_fn(0), 8'hFF)) begin
            q.push_back(mk(1, 1, 1, 0, 0, 1, 0, 0));
            exp_err = 1; exp_fail = 0;
            return;
        end
        q.push_back(mk(1, 1, 1, 0, 0, 1, 0, 0));
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cmp(ent_t x);
        vectors++;
        chk(mem_pgm_n == x.pgm_n, "R1", "pgm_n", int'(mem_pgm_n), int'(x.pgm_n));
        chk(mem_ce_n == x.ce_n, "R1", "ce_n", int'(mem_ce_n), int'(x.ce_n));
        chk(mem_oe_n == x.oe_n, "R2", "oe_n", int'(mem_oe_n), int'(x.oe_n));
        chk(hv_phase == x.hv, "R9", "hv_phase", int'(hv_phase), int'(x.hv));
        chk(vfy_phase == x.vfy, "R5", "vfy_phase", int'(vfy_phase), int'(x.vfy));
        chk(done == x.dn, "R8", "done", int'(done), int'(x.dn));
        if (!x.ce_n) chk(mem_addr == x.a, "R4", "mem_addr", int'(mem_addr), int'(x.a));
        if (!x.pgm_n) chk(mem_wdata == x.d, "R1", "mem_wdata", int'(mem_wdata), int'(x.d));
    endtask

    task automatic run(int s, int e);
        ent_t x;
        build(s, e);
        mem_a.delete(); hit_a.delete();
        @(negedge clk);
        start_addr = AW'(s); end_addr = AW'(e); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (q.size() > 0) begin
            x = q.pop_front();
            cmp(x);
            if (q.size() > 0) @(negedge clk);
        end
        vectors++;
        chk(pass == (exp_err == 0), "R8", "pass", int'(pass), int'(exp_err == 0));
        chk(int'(err_code) == exp_err, exp_err == 1 ? "R3" : (exp_err == 2 ? "R6" : "R8"),
            "err_code", int'(err_code), exp_err);
        if (exp_err != 0)
            chk(int'(fail_addr) == exp_fail, exp_err == 1 ? "R3" : "R6", "fail_addr",
                int'(fail_addr), exp_fail);
    endtask

    task automatic reset_cfg(int sd);
        need_m.delete(); dsrc = -1; use_b0 = 0; seed = sd;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        vectors++;
        chk(done == 0 && err_code == 0 && hv_phase == 0 && vfy_phase == 0, "R10",
            "status in reset", int'({done, err_code, hv_phase, vfy_phase}), 0);
        chk(mem_pgm_n && mem_ce_n && mem_oe_n, "R10", "strobes in reset",
            int'({mem_pgm_n, mem_ce_n, mem_oe_n}), 7);
        rst_n = 1'b1;
        @(negedge clk);
        vectors++;
        chk(!done && mem_pgm_n && mem_ce_n, "R10", "idle after reset",
            int'({done, mem_pgm_n, mem_ce_n}), 3);

        // Plain window, one pulse per byte.
        reset_cfg(1); run(16, 23);
        // Slow cells, including one needing exactly the limit.
        reset_cfg(2); need_m[41] = 3; need_m[43] = MAXT; run(40, 43);
        // One pulse too many: retry overflow (R3), no strobe afterwards.
        reset_cfg(3); need_m[61] = MAXT + 1; run(60, 62);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            vectors++;
            chk(mem_pgm_n && done, "R3", "quiet after overflow",
                int'({mem_pgm_n, done}), 3);
        end
        // Neighbour disturb caught by final readback (R6).
        reset_cfg(4); dsrc = 82; dvic = 80; dmask = 8'h00; run(80, 83);
        // Read fuse requested in image byte 0 (R7).
        reset_cfg(5); use_b0 = 1; byte0 = 8'hA4; run(0, 3);
        vectors++;
        chk(raw(0, 0) == 8'hA4, "R7", "fuse byte in array", int'(raw(0, 0)), 8'hA4);
        chk(rd(0, 2) == 8'hFF, "R7", "protected read", int'(rd(0, 2)), 8'hFF);
        // Byte 0 with fuse bit left at one: no extra loop (R7).
        reset_cfg(6); use_b0 = 1; byte0 = 8'hA5; run(0, 2);
        // One-address window at the top of the range (R4).
        reset_cfg(7); run(17'h1FFFF, 17'h1FFFF);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule